// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Unit

This block keeps the interrupt event flags for a multi-channel DMA controller. Each channel's transfer engine gives it three one-cycle pulses: a transfer error, reaching the halfway point, and completion. The block turns each pulse into a sticky flag. It also keeps a per-channel summary flag that is set by any of the three events.

All flags are packed into one read-only status word. Software reads this word over a simple register bus. To clear flags, software writes ones to a separate clear word. Writing to the status word never changes a flag.

Each channel also drives one interrupt line. The line is the registered OR of that channel's event flags, each gated by its own enable bit.

Top module: `dma_irq_flags`

## Requirements
- R1: Channel c (0-based) owns status bits [4c+3:4c]. Bit 4c+3 is the error flag, 4c+2 the half flag, 4c+1 the done flag and 4c+0 the summary flag. The status word is at byte offset 0x0 and the clear word at byte offset 0x4.
- R2: After reset, every flag, every interrupt line and the read data are zero.
- R3: An event pulse sets its flag at the next clock edge. The flag then stays set until it is cleared. A second pulse on a flag that is already set changes nothing.
- R4: Any error, half or done pulse on a channel also sets that channel's summary flag.
- R5: A write to the clear word clears every flag whose bit is 1 in the written data. Bits written as 0 leave their flags unchanged.
- R6: Clearing a channel's summary bit clears all four of that channel's flags. Clearing a single event bit leaves the summary flag set.
- R7: When a set pulse and a clear of the same flag fall in the same cycle, the flag is 1 afterwards.
- R8: Writes to the status offset have no effect. A read of the clear offset returns zero.
- R9: irq[c] is registered from the channel's flags. It is the OR of (error & en_err), (half & en_half) and (done & en_done), and it follows the flags one clock later.
- R10: bus_rdata is registered. On the edge after a cycle with bus_rd high at the status offset, it holds the status word as it stood at that edge. On every other edge it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_err | input | N_CH | Error event pulse, one bit per channel |
| evt_half | input | N_CH | Half-way event pulse, one bit per channel |
| evt_done | input | N_CH | Completion event pulse, one bit per channel |
| en_err | input | N_CH | Interrupt enable for the error flag |
| en_half | input | N_CH | Interrupt enable for the half flag |
| en_done | input | N_CH | Interrupt enable for the done flag |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4*N_CH | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 4*N_CH | Registered read data |
| irq | output | N_CH | Registered interrupt line per channel |

## Verification
The bench uses the default parameters: eight channels and a four-bit byte offset. The status word is therefore a full 32 bits wide, so the top channel's group in bits 31:28 can be set, cleared and read back. The bench also visits every channel's half flag in turn. With both offsets on the same narrow address bus, the bench can write the status word, read the clear word and issue a set together with a clear in the same cycle.

// File: rtl/dif_pkg.sv
package dif_pkg;
  localparam int GRP_W    = 4;
  localparam int FLD_GLB  = 0;
  localparam int FLD_DONE = 1;
  localparam int FLD_HALF = 2;
  localparam int FLD_ERR  = 3;
endpackage

// File: rtl/dif_chan.sv
module dif_chan
  import dif_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_err,
  input  logic             ev_half,
  input  logic             ev_done,
  input  logic [GRP_W-1:0] clr,
  input  logic             en_err,
  input  logic             en_half,
  input  logic             en_done,
  output logic [GRP_W-1:0] flags,
  output logic             irq
);
  logic [GRP_W-1:0] nxt;
  logic             kill_all;

  always_comb begin
    kill_all      = clr[FLD_GLB];
    nxt[FLD_ERR]  = ev_err  | (flags[FLD_ERR]  & ~clr[FLD_ERR]  & ~kill_all);
    nxt[FLD_HALF] = ev_half | (flags[FLD_HALF] & ~clr[FLD_HALF] & ~kill_all);
    nxt[FLD_DONE] = ev_done | (flags[FLD_DONE] & ~clr[FLD_DONE] & ~kill_all);
    nxt[FLD_GLB]  = ev_err | ev_half | ev_done | (flags[FLD_GLB] & ~kill_all);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= nxt;
      irq   <= (flags[FLD_ERR] & en_err) | (flags[FLD_HALF] & en_half) |
               (flags[FLD_DONE] & en_done);
    end
  end

  // Flag is sticky while no clear hits it
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (flags[FLD_ERR] && !clr[FLD_ERR] && !clr[FLD_GLB]) |=> flags[FLD_ERR]);

  // Set wins over a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> flags[FLD_DONE]);

  // Any event raises the summary flag
  p_glob_set_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_err || ev_half || ev_done) |=> flags[FLD_GLB]);

  // An event flag never stands without its summary flag
  p_glob_cover_r6: assert property (@(posedge clk) disable iff (rst)
    (flags[FLD_ERR] || flags[FLD_HALF] || flags[FLD_DONE]) |-> flags[FLD_GLB]);

  // Summary clear with no event empties the group
  p_glob_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr[FLD_GLB] && !ev_err && !ev_half && !ev_done) |=> (flags == '0));

  // No enable, no interrupt
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_err && !en_half && !en_done) |=> !irq);
endmodule

// File: rtl/dif_bus.sv
module dif_bus #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int STS_OFF = 0,
  parameter int CLR_OFF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_OFF);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CLR_OFF);

  logic hit_sts_rd;

  always_comb begin
    clr_vec    = (wr && addr == A_CLR) ? wdata : '0;
    hit_sts_rd = rd && (addr == A_STS);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= hit_sts_rd ? status : '0;
  end

  // Reads away from the status offset return zero
  p_rd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !(rd && addr == A_STS) |=> (rdata == '0));

  // Status read returns the word of the sampling edge
  p_rd_value_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_STS) |=> (rdata == $past(status)));
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dif_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int ADDR_W  = 4,
  parameter int STS_OFF = 0,
  parameter int CLR_OFF = 4,
  localparam int SW     = GRP_W * N_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   evt_err,
  input  logic [N_CH-1:0]   evt_half,
  input  logic [N_CH-1:0]   evt_done,
  input  logic [N_CH-1:0]   en_err,
  input  logic [N_CH-1:0]   en_half,
  input  logic [N_CH-1:0]   en_done,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [SW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [SW-1:0]     bus_rdata,
  output logic [N_CH-1:0]   irq
);
  logic [SW-1:0] status;
  logic [SW-1:0] clr_vec;

  dif_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (SW),
    .STS_OFF(STS_OFF),
    .CLR_OFF(CLR_OFF)
  ) u_bus (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .wdata  (bus_wdata),
    .rd     (bus_rd),
    .status (status),
    .clr_vec(clr_vec),
    .rdata  (bus_rdata)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dif_chan u_ch (
      .clk    (clk),
      .rst    (rst),
      .ev_err (evt_err[c]),
      .ev_half(evt_half[c]),
      .ev_done(evt_done[c]),
      .clr    (clr_vec[GRP_W*c +: GRP_W]),
      .en_err (en_err[c]),
      .en_half(en_half[c]),
      .en_done(en_done[c]),
      .flags  (status[GRP_W*c +: GRP_W]),
      .irq    (irq[c])
    );
  end
endmodule

// File: tb/tb_dma_irq_flags.sv
module tb_dma_irq_flags;
  localparam int N = 8;
  localparam logic [3:0] STS = 4'h0, CLR = 4'h4;

  logic clk = 0, rst = 1;
  logic [N-1:0] evt_err = 0, evt_half = 0, evt_done = 0;
  logic [N-1:0] en_err = 0, en_half = 0, en_done = 0;
  logic [3:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] irq;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  dma_irq_flags dut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(logic [N-1:0] e, logic [N-1:0] h, logic [N-1:0] d);
    evt_err = e; evt_half = h; evt_done = d;
    @(negedge clk);
    evt_err = 0; evt_half = 0; evt_done = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R2 rdata", bus_rdata, 0);
    check("R2 irq", 32'(irq), 0);
    rd(STS, v); check("R2 status", v, 0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    pulse(8'h80, 0, 0); rd(STS, v); check("R1 ch7 err", v, 32'h9000_0000);
    wr(CLR, 32'hFFFF_FFFF); rd(STS, v); check("R5 clear all", v, 0);
    for (int c = 0; c < N; c++) begin
      pulse(0, 8'(1 << c), 0); rd(STS, v);
      check("R1 half per channel", v, 32'h5 << (4 * c));
      wr(CLR, 32'h1 << (4 * c));
    end
    pulse(0, 0, 8'h01); rd(STS, v); check("R4 ch0 done+glob", v, 32'h3);
    wr(CLR, 32'h1);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    pulse(8'h04, 0, 0); pulse(8'h04, 0, 0);
    rd(STS, v); check("R3 repeat pulse", v, 32'h900);
    rd(STS, v); check("R3 holds", v, 32'h900);
    wr(CLR, 32'h0); rd(STS, v); check("R5 zero write", v, 32'h900);
    wr(CLR, 32'h800); rd(STS, v); check("R6 glob kept", v, 32'h100);
    wr(CLR, 32'h100); rd(STS, v); check("R5 glob cleared", v, 0);
  endtask

  task automatic t_glob_clear();
    logic [31:0] v;
    pulse(8'h08, 8'h08, 8'h08); rd(STS, v); check("R4 all events", v, 32'hF000);
    wr(CLR, 32'h1000); rd(STS, v); check("R6 glob clears group", v, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    pulse(0, 0, 8'h02);
    evt_done = 8'h02; bus_addr = CLR; bus_wdata = 32'h20; bus_wr = 1;
    @(negedge clk);
    evt_done = 0; bus_wr = 0;
    rd(STS, v); check("R7 set wins", v, 32'h30);
    wr(CLR, 32'h10);
  endtask

  task automatic t_bus_side();
    logic [31:0] v;
    pulse(0, 8'h10, 0);
    wr(STS, 32'hFFFF_FFFF); rd(STS, v); check("R8 status write ignored", v, 32'h5_0000);
    rd(CLR, v); check("R8 clear read zero", v, 0);
    @(negedge clk); check("R10 idle rdata zero", bus_rdata, 0);
    wr(CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    en_err = 8'hFF;
    pulse(0, 8'h01, 0); @(negedge clk); check("R9 masked half", 32'(irq), 0);
    pulse(8'h01, 0, 0); @(negedge clk); check("R9 err irq", 32'(irq), 32'h01);
    en_done = 8'h20;
    pulse(0, 0, 8'h20); @(negedge clk); check("R9 done irq", 32'(irq), 32'h21);
    en_err = 0; en_done = 0;
    @(negedge clk); check("R9 disabled", 32'(irq), 0);
    en_half = 8'h01;
    @(negedge clk); check("R9 half enabled", 32'(irq), 32'h01);
    en_half = 0;
    wr(CLR, 32'hFFFF_FFFF);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_sticky();
    t_glob_clear();
    t_set_wins();
    t_bus_side();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule